// File: doc/BRIEF.md
# DRAM Refresh Interval Timer

This block sets the pace of refreshes for a DRAM controller. A free-running prescaler divides the system clock by a factor picked by a 3-bit select field. An 8-bit interval counter advances on each prescaled tick. When that counter reaches the value in the compare register, it wraps to zero and the block emits a one-cycle refresh request. Each request also sets a sticky match flag and adds one to an 11-bit saturating refresh tally.

The tally is compared against a limit of 512 or 1024, chosen by one bit. When a request pushes the tally above that limit, an overflow flag is set. The overflow flag drives an interrupt output through an enable bit. Software reaches all state through a small 16-bit register port. Every write must carry the key byte 0xA5 in its upper half, and any write without it is dropped.

The block tells three conditions apart. Power-on reset clears everything. Manual reset clears the flags and the tally, but the timer keeps its clock selection, compare value and count. Standby freezes the prescaler and the count so that no refresh is missed or invented.

Top module: `dram_refresh_timer`

## Requirements
- R1: Clock-select codes 1 to 7 (control bits [2:0]) give one counter tick every 4, 16, 64, 256, 1024, 2048 or 4096 clocks, so that refresh requests come (compare+1)×divisor clocks apart. Code 0 stops the counter.
- R2: On a tick where the counter equals the compare value, the counter returns to 0 and refresh_req_o pulses high for exactly one cycle on the following cycle. A compare value of 0 produces a request on every tick.
- R3: A register write takes effect only when reg_wdata_i[15:8] is 0xA5, with the data in reg_wdata_i[7:0]. Any other write leaves every register unchanged.
- R4: Register map by reg_addr_i: 0 is control, 1 is the interval counter, 2 is compare, and 3 is the refresh tally. reg_rdata_o shows the addressed value, zero-extended, in the same cycle. Control layout: [2:0] clock select, [3] match flag, [4] overflow flag, [5] interrupt enable, [6] limit select.
- R5: Each refresh request adds one to the refresh tally, which saturates at 2047. A keyed write to address 3 loads the tally with the data byte, so writing zero clears it.
- R6: A refresh request that leaves the tally above the limit sets the overflow flag. The limit is 1024 when limit select is 0 and 512 when it is 1.
- R7: Writing 0 to a flag bit (match or overflow) clears it. Writing 1 leaves it unchanged. A set event in the same cycle wins over the clear.
- R8: irq_o is high exactly when both the overflow flag and the interrupt enable are set.
- R9: Power-on reset (rst_ni low) clears every register, the prescaler and the interval counter. Limit select resets to 0, which selects 1024.
- R10: A one-cycle man_rst_i clears the flags, the interrupt enable, the limit select and the tally. It keeps the clock select, the compare value and the interval counter, so counting continues.
- R11: While standby_i is high, the prescaler and the interval counter hold their values and no refresh request is produced. The count resumes when standby_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| man_rst_i | input | 1 | Manual reset, synchronous, active high |
| standby_i | input | 1 | Freeze prescaler and interval counter |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 16 | Write word: key in [15:8], data in [7:0] |
| reg_rdata_o | output | 16 | Read data for the addressed register |
| refresh_req_o | output | 1 | One-cycle refresh request |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The assertions assume that a write to the interval counter is the only thing besides a tick that may move the count. They also assume that the smallest divisor, 4, keeps requests at least four cycles apart. The stimulus drives every write strobe and reset for a single cycle from the falling edge.

Before each interval measurement, the bench parks the counter at zero with clock select 0. That keeps the first request within compare+1 ticks. Every stop of the timer is written in the cycle right after a request, so it lands well before the next prescaled tick.

// File: rtl/rfsh_pkg.sv
`timescale 1ns/1ps
package rfsh_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CNT  = 2'd1,
    REG_CMP  = 2'd2,
    REG_TALY = 2'd3
  } reg_sel_e;

  localparam logic [7:0] WR_KEY = 8'hA5;

  // log2 of the prescale divisor for each clock-select code
  function automatic int unsigned div_shift(input logic [2:0] sel);
    case (sel)
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      3'd6:    return 11;
      3'd7:    return 12;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/rt_prescale.sv
`timescale 1ns/1ps
module rt_prescale
  import rfsh_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hold_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  localparam int unsigned PRE_W = div_shift(3'd7);

  logic [PRE_W-1:0] pre_q;
  logic [7:0]       tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (!hold_i) pre_q <= pre_q + 1'b1;
  end

  assign tap[0] = 1'b0;
  for (genvar g = 1; g < 8; g++) begin : g_tap
    localparam int unsigned SH = div_shift(3'(g));
    assign tap[g] = &pre_q[SH-1:0];
  end

  assign tick_o = !hold_i && tap[sel_i];
endmodule

// File: rtl/rt_interval.sv
`timescale 1ns/1ps
module rt_interval #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q;

  // a write to the counter wins and suppresses the match of that cycle
  assign match_o = tick_i && !wr_i && (cnt_q == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wr_i)    cnt_q <= wdata_i;
    else if (match_o) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rt_tally.sv
`timescale 1ns/1ps
module rt_tally #(
  parameter int unsigned RC_W   = 11,
  parameter int unsigned LIM_HI = 1024,
  parameter int unsigned LIM_LO = 512
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            inc_i,
  input  logic            wr_i,
  input  logic [7:0]      wdata_i,
  input  logic            lim_sel_i,
  output logic [RC_W-1:0] tally_o,
  output logic            over_o
);
  localparam logic [RC_W-1:0] LIM_A = RC_W'(LIM_HI);
  localparam logic [RC_W-1:0] LIM_B = RC_W'(LIM_LO);

  logic [RC_W-1:0] tally_q, tally_nx, limit;

  assign limit    = lim_sel_i ? LIM_B : LIM_A;
  assign tally_nx = (&tally_q) ? tally_q : tally_q + 1'b1;
  assign over_o   = inc_i && !wr_i && !clr_i && (tally_nx > limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tally_q <= '0;
    else if (clr_i)  tally_q <= '0;
    else if (wr_i)   tally_q <= RC_W'(wdata_i);
    else if (inc_i)  tally_q <= tally_nx;
  end

  assign tally_o = tally_q;
endmodule

// File: rtl/dram_refresh_timer.sv
`timescale 1ns/1ps
module dram_refresh_timer
  import rfsh_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned RC_W   = 11,
  parameter int unsigned LIM_HI = 1024,
  parameter int unsigned LIM_LO = 512
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        man_rst_i,
  input  logic        standby_i,
  input  logic        reg_wr_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        refresh_req_o,
  output logic        irq_o
);
  logic             wr_ok;
  logic             wr_ctrl, wr_cnt, wr_cmp, wr_taly;
  logic [7:0]       wbyte;
  logic [2:0]       clk_sel_q;
  logic             cmf_q, ovf_q, ovie_q, lim_q, req_q;
  logic [CNT_W-1:0] cmp_q, cnt_w;
  logic [RC_W-1:0]  rcnt_w;
  logic             tick, match, over;

  assign wbyte   = reg_wdata_i[7:0];
  assign wr_ok   = reg_wr_i && (reg_wdata_i[15:8] == WR_KEY);
  assign wr_ctrl = wr_ok && (reg_addr_i == REG_CTRL);
  assign wr_cnt  = wr_ok && (reg_addr_i == REG_CNT);
  assign wr_cmp  = wr_ok && (reg_addr_i == REG_CMP);
  assign wr_taly = wr_ok && (reg_addr_i == REG_TALY);

  rt_prescale u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (standby_i),
    .sel_i  (clk_sel_q),
    .tick_o (tick)
  );

  rt_interval #(.CNT_W(CNT_W)) u_ivl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .wr_i    (wr_cnt),
    .wdata_i (wbyte[CNT_W-1:0]),
    .cmp_i   (cmp_q),
    .cnt_o   (cnt_w),
    .match_o (match)
  );

  rt_tally #(.RC_W(RC_W), .LIM_HI(LIM_HI), .LIM_LO(LIM_LO)) u_tly (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (man_rst_i),
    .inc_i     (match),
    .wr_i      (wr_taly),
    .wdata_i   (wbyte),
    .lim_sel_i (lim_q),
    .tally_o   (rcnt_w),
    .over_o    (over)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sel_q <= '0;
      cmf_q     <= 1'b0;
      ovf_q     <= 1'b0;
      ovie_q    <= 1'b0;
      lim_q     <= 1'b0;
    end else if (man_rst_i) begin
      cmf_q     <= 1'b0;
      ovf_q     <= 1'b0;
      ovie_q    <= 1'b0;
      lim_q     <= 1'b0;
    end else if (wr_ctrl) begin
      clk_sel_q <= wbyte[2:0];
      cmf_q     <= (cmf_q & wbyte[3]) | match;
      ovf_q     <= (ovf_q & wbyte[4]) | over;
      ovie_q    <= wbyte[5];
      lim_q     <= wbyte[6];
    end else begin
      cmf_q     <= cmf_q | match;
      ovf_q     <= ovf_q | over;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= match;
      if (wr_cmp) cmp_q <= wbyte[CNT_W-1:0];
    end
  end

  always_comb begin
    case (reg_sel_e'(reg_addr_i))
      REG_CTRL: reg_rdata_o = {8'h00, 1'b0, lim_q, ovie_q, ovf_q, cmf_q, clk_sel_q};
      REG_CNT:  reg_rdata_o = 16'(cnt_w);
      REG_CMP:  reg_rdata_o = 16'(cmp_q);
      default:  reg_rdata_o = 16'(rcnt_w);
    endcase
  end

  assign refresh_req_o = req_q;
  assign irq_o         = ovf_q && ovie_q;
endmodule

// File: rtl/rt_checker.sv
`timescale 1ns/1ps
module rt_checker #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned RC_W  = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             man_rst_i,
  input logic             standby_i,
  input logic             reg_wr_i,
  input logic [1:0]       reg_addr_i,
  input logic [15:0]      reg_wdata_i,
  input logic             refresh_req_o,
  input logic             irq_o,
  input logic [2:0]       clk_sel_q,
  input logic [CNT_W-1:0] cnt_w,
  input logic [CNT_W-1:0] cmp_q,
  input logic [RC_W-1:0]  rcnt_w,
  input logic             ovf_q
);
  logic keyed, cnt_wr, taly_wr;
  assign keyed   = reg_wr_i && (reg_wdata_i[15:8] == 8'hA5);
  assign cnt_wr  = keyed && (reg_addr_i == 2'd1);
  assign taly_wr = keyed && (reg_addr_i == 2'd3);

  assert_stop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_q == 3'd0 && !cnt_wr) |=> $stable(cnt_w));

  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_req_o |-> (cnt_w == '0));

  assert_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_req_o |=> !refresh_req_o);

  assert_unkeyed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_wdata_i[15:8] != 8'hA5) |=> $stable(cmp_q));

  assert_saturate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&rcnt_w) && !taly_wr && !man_rst_i) |=> (&rcnt_w));

  assert_ovf_on_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> refresh_req_o);

  assert_irq_needs_ovf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ovf_q);

  assert_standby_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_i && !cnt_wr) |=> $stable(cnt_w));
endmodule

bind dram_refresh_timer rt_checker #(.CNT_W(CNT_W), .RC_W(RC_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .man_rst_i     (man_rst_i),
  .standby_i     (standby_i),
  .reg_wr_i      (reg_wr_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wdata_i   (reg_wdata_i),
  .refresh_req_o (refresh_req_o),
  .irq_o         (irq_o),
  .clk_sel_q     (clk_sel_q),
  .cnt_w         (cnt_w),
  .cmp_q         (cmp_q),
  .rcnt_w        (rcnt_w),
  .ovf_q         (ovf_q)
);

// File: tb/dram_refresh_timer_test.sv
`timescale 1ns/1ps
module dram_refresh_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        man_rst_i = 1'b0;
  logic        standby_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [15:0] reg_wdata_i = 16'h0;
  logic [15:0] reg_rdata_o;
  logic        refresh_req_o, irq_o;

  int total = 0;
  int fails = 0;

  always #4 clk_i = ~clk_i;

  dram_refresh_timer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .man_rst_i(man_rst_i), .standby_i(standby_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .refresh_req_o(refresh_req_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic wk(input logic [1:0] a, input logic [7:0] d);
    wr(a, {8'hA5, d});
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr_i = a;
    #1 v = int'(reg_rdata_o);
  endtask

  task automatic wait_req();
    do @(negedge clk_i); while (!refresh_req_o);
  endtask

  task automatic park(input logic [7:0] cmp);
    wk(2'd0, 8'h00); wk(2'd1, 8'h00); wk(2'd2, cmp);
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R9", $sformatf("reg %0d after power-on", a), v, 0);
    end
    chk("R9", "req idle", int'(refresh_req_o), 0);
    chk("R9", "irq idle", int'(irq_o), 0);
  endtask

  task automatic t_key();
    int v;
    wr(2'd2, 16'h0010); rd(2'd2, v); chk("R3", "unkeyed cmp", v, 0);
    wr(2'd0, 16'h5A61); rd(2'd0, v); chk("R3", "bad key ctrl", v, 0);
    wr(2'd1, 16'h0033); rd(2'd1, v); chk("R3", "unkeyed cnt", v, 0);
    wk(2'd2, 8'h10);    rd(2'd2, v); chk("R4", "keyed cmp", v, 16'h10);
    wk(2'd3, 8'h07);    rd(2'd3, v); chk("R5", "keyed tally load", v, 7);
    wk(2'd3, 8'h00);    rd(2'd3, v); chk("R5", "tally clear", v, 0);
  endtask

  task automatic t_interval(input logic [2:0] sel, input logic [7:0] cmp, input int exp);
    int n;
    park(cmp);
    wk(2'd0, {5'b0, sel});
    wait_req();
    n = 0;
    do begin @(negedge clk_i); n++; end while (!refresh_req_o);
    chk("R1", $sformatf("interval sel %0d cmp %0d", sel, cmp), n, exp);
  endtask

  task automatic t_pulse();
    int v, hi;
    park(8'd2);
    wk(2'd0, 8'h01);
    wait_req();
    rd(2'd1, v); chk("R2", "counter wraps to 0", v, 0);
    hi = 0;
    @(negedge clk_i); hi += int'(refresh_req_o);
    chk("R2", "pulse one cycle", hi, 0);
    rd(2'd0, v); chk("R2", "match flag set", (v >> 3) & 1, 1);
    wk(2'd0, 8'h09); rd(2'd0, v); chk("R7", "write 1 keeps match flag", (v >> 3) & 1, 1);
    wk(2'd0, 8'h00); rd(2'd0, v); chk("R7", "write 0 clears match flag", (v >> 3) & 1, 0);
  endtask

  task automatic t_stop();
    int a, b;
    park(8'd0);
    wk(2'd1, 8'h42);
    rd(2'd1, a);
    repeat (200) @(negedge clk_i);
    rd(2'd1, b);
    chk("R1", "select 0 stops counter", b, a);
  endtask

  task automatic run_pulses(input int n, input logic [7:0] ctrl_run);
    wk(2'd0, ctrl_run);
    repeat (n) wait_req();
    wk(2'd0, (ctrl_run & 8'hF8) | 8'h18);
  endtask

  task automatic t_ovf512();
    int v;
    park(8'd0); wk(2'd3, 8'h00);
    run_pulses(512, 8'h61);
    rd(2'd3, v); chk("R5", "tally after 512", v, 512);
    rd(2'd0, v); chk("R6", "no ovf at 512 (lim 512)", (v >> 4) & 1, 0);
    chk("R8", "irq low before ovf", int'(irq_o), 0);
    run_pulses(1, 8'h79);
    rd(2'd3, v); chk("R5", "tally 513", v, 513);
    rd(2'd0, v); chk("R6", "ovf above 512", (v >> 4) & 1, 1);
    chk("R8", "irq with enable", int'(irq_o), 1);
    wk(2'd0, 8'h58);
    chk("R8", "irq masked", int'(irq_o), 0);
    rd(2'd0, v); chk("R7", "write 1 keeps ovf", (v >> 4) & 1, 1);
    wk(2'd0, 8'h40);
    rd(2'd0, v); chk("R7", "write 0 clears ovf", (v >> 4) & 1, 0);
  endtask

  task automatic t_ovf1024();
    int v;
    park(8'd0); wk(2'd3, 8'h00);
    run_pulses(1024, 8'h21);
    rd(2'd3, v); chk("R5", "tally after 1024", v, 1024);
    rd(2'd0, v); chk("R6", "no ovf at 1024 (lim 1024)", (v >> 4) & 1, 0);
    run_pulses(1, 8'h39);
    rd(2'd0, v); chk("R6", "ovf above 1024", (v >> 4) & 1, 1);
    run_pulses(1030, 8'h39);
    rd(2'd3, v); chk("R5", "tally saturates", v, 2047);
  endtask

  task automatic t_manual();
    int v;
    park(8'd5);
    wk(2'd1, 8'h33);
    wk(2'd3, 8'h09);
    wk(2'd0, 8'h60);
    @(negedge clk_i); man_rst_i = 1'b1;
    @(negedge clk_i); man_rst_i = 1'b0;
    rd(2'd1, v); chk("R10", "counter kept", v, 16'h33);
    rd(2'd2, v); chk("R10", "compare kept", v, 5);
    rd(2'd3, v); chk("R10", "tally cleared", v, 0);
    rd(2'd0, v); chk("R10", "ctrl cleared", v, 0);
    wk(2'd1, 8'h00);
    wk(2'd0, 8'h01);
    @(negedge clk_i); man_rst_i = 1'b1;
    @(negedge clk_i); man_rst_i = 1'b0;
    rd(2'd0, v); chk("R10", "clock select kept", v & 7, 1);
    wait_req(); v = 0;
    do begin @(negedge clk_i); v++; end while (!refresh_req_o);
    chk("R10", "counting continues", v, 24);
  endtask

  task automatic t_standby();
    int a, b, seen;
    park(8'd5);
    wk(2'd0, 8'h01);
    @(negedge clk_i); standby_i = 1'b1;
    @(negedge clk_i); rd(2'd1, a);
    seen = 0;
    repeat (100) begin @(negedge clk_i); seen += int'(refresh_req_o); end
    rd(2'd1, b);
    chk("R11", "count held", b, a);
    chk("R11", "no request in standby", seen, 0);
    standby_i = 1'b0;
    seen = 0;
    repeat (40) begin @(negedge clk_i); seen += int'(refresh_req_o); end
    chk("R11", "requests resume", int'(seen > 0), 1);
  endtask

  task automatic t_por();
    int v;
    wk(2'd2, 8'h44); wk(2'd0, 8'h61);
    repeat (20) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rd(2'd1, v); chk("R9", "counter 0 on power-on", v, 0);
    rd(2'd2, v); chk("R9", "compare 0 on power-on", v, 0);
    rd(2'd0, v); chk("R9", "ctrl 0 (limit 1024) on power-on", v, 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_key();
    t_interval(3'd1, 8'd3, 16);
    t_interval(3'd2, 8'd1, 32);
    t_interval(3'd1, 8'd0, 4);   // R2: compare 0 -> every tick
    t_interval(3'd5, 8'd0, 1024);
    t_interval(3'd7, 8'd0, 4096);
    t_pulse();
    t_stop();
    t_ovf512();
    t_ovf1024();
    t_manual();
    t_standby();
    t_por();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule